// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio N = B·P + A and emits one single-cycle pulse per N input cycles, meant for the feedback side of a phase detector. It does this with a digital dual-modulus prescaler, which counts either P or P+1 input cycles per period. A swallow counter A and a main counter B, both stepped once per prescaler period, decide which modulus is used. Within one output cycle the prescaler runs A periods of P+1 and then B−A periods of P.

A new configuration is presented on `psel`, `a_val` and `b_val` together with a one-cycle `load` strobe. A legal configuration is held as pending and applied at the next output-cycle boundary, so no runt or stretched cycle is produced. An illegal configuration raises `cfg_err` and is discarded, and the divider keeps its last legal ratio.

The control is a two-state machine. In ST_SWALLOW the prescaler uses P+1. In ST_MAIN it uses P. Each prescaler period ends with a tick, and the transitions happen on ticks:
- T_SWALLOW_DONE goes from ST_SWALLOW to ST_MAIN on the tick that takes the swallow count to zero.
- T_RELOAD_SW enters ST_SWALLOW on the tick where the main count expires and the reloaded A is nonzero.
- T_RELOAD_MAIN enters ST_MAIN on the same boundary tick when the reloaded A is zero.

Top module: `pulse_swallow_divider`

## Requirements
- R1: After reset `div_out` and `cfg_err` are low and the ratio is P=8 (psel 0), A=0, B=3, so the first pulse follows 24 input cycles after reset release.
- R2: `div_out` is high for exactly one input cycle once every B·P+A input cycles.
- R3: `psel` encodes the modulus pair: 0 selects 8/9, 1 selects 16/17, 2 selects 32/33.
- R4: Within each output cycle the prescaler counts P+1 cycles for the first A of its periods and P cycles for the remaining B−A periods.
- R5: A `load` with psel 3, with B below 3, or with A greater than B sets `cfg_err` on the next cycle. The values are discarded, and both the running ratio and any pending legal ratio are unchanged.
- R6: A `load` with legal values clears `cfg_err` on the next cycle.
- R7: A legal load takes effect only at the next output pulse boundary. The current output cycle completes with the old ratio, and when several legal loads arrive before a boundary the last one is used.
- R8: The extreme swallow settings A=0 (all periods P) and A=B (all periods P+1) give ratios B·P and B·(P+1).
- R9: The ratios P²−P and P²−P+1 are reachable, using B=P−1 with A=0 and A=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle strobe capturing psel, a_val and b_val |
| psel | input | 2 | Prescaler modulus select (0: 8/9, 1: 16/17, 2: 32/33, 3: illegal) |
| a_val | input | AW (5) | Swallow count A |
| b_val | input | BW (13) | Main count B |
| div_out | output | 1 | One-cycle pulse per output cycle |
| cfg_err | output | 1 | Last load was illegal |

## Verification
The assertions rely on the active configuration always satisfying A ≤ B and B ≥ 3. The filter on `load` guarantees this, so they stay valid even when the bench deliberately offers illegal sets. The single-cycle pulse check also relies on the smallest legal ratio being 24, which is far above two cycles. The bench draws random sets with B from 3 to 40 and A no greater than B, which keeps each output cycle short. Separate directed loads use psel 3, B of 2, and A greater than B to exercise the rejection path.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

    typedef enum logic [0:0] {
        ST_SWALLOW = 1'b0,
        ST_MAIN    = 1'b1
    } pswl_phase_t;

    localparam int SEL_W = 2;
    localparam int PC_W  = 6;

    function automatic logic [PC_W-1:0] low_modulus(input logic [SEL_W-1:0] sel);
        logic [PC_W-1:0] m;
        case (sel)
            2'd0:    m = 6'd8;
            2'd1:    m = 6'd16;
            default: m = 6'd32;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pswl_cfg.sv
module pswl_cfg
    import pswl_pkg::*;
#(
    parameter int AW = 5,
    parameter int BW = 13,
    parameter logic [SEL_W-1:0] DEF_SEL = '0,
    parameter logic [AW-1:0] DEF_A = '0,
    parameter logic [BW-1:0] DEF_B = 13'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [AW-1:0]    a_in,
    input  logic [BW-1:0]    b_in,
    input  logic             boundary,
    output logic [SEL_W-1:0] act_sel,
    output logic [AW-1:0]    nxt_a,
    output logic [BW-1:0]    nxt_b,
    output logic             cfg_err
);

    localparam logic [BW-1:0] B_MIN = BW'(3);

    logic [SEL_W-1:0] pend_sel;
    logic [AW-1:0]    pend_a, act_a;
    logic [BW-1:0]    pend_b, act_b;
    logic             pend_v;
    logic             legal;

    always_comb begin
        legal = (sel_in != 2'd3) && (b_in >= B_MIN) &&
                ({{(BW-AW){1'b0}}, a_in} <= b_in);
        nxt_a = pend_v ? pend_a : act_a;
        nxt_b = pend_v ? pend_b : act_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sel  <= DEF_SEL;
            act_a    <= DEF_A;
            act_b    <= DEF_B;
            pend_sel <= DEF_SEL;
            pend_a   <= DEF_A;
            pend_b   <= DEF_B;
            pend_v   <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            if (boundary && pend_v) begin
                act_sel <= pend_sel;
                act_a   <= pend_a;
                act_b   <= pend_b;
                pend_v  <= 1'b0;
            end
            if (load) begin
                cfg_err <= !legal;
                if (legal) begin
                    pend_sel <= sel_in;
                    pend_a   <= a_in;
                    pend_b   <= b_in;
                    pend_v   <= 1'b1;
                end
            end
        end
    end

    assert_act_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable({act_sel, act_a, act_b}));

    assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_err));

    assert_act_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(BW-AW){1'b0}}, act_a} <= act_b) && (act_b >= B_MIN) && (act_sel != 2'd3));

endmodule

// File: rtl/pswl_prescaler.sv
module pswl_prescaler
    import pswl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             hi_mod,
    output logic             tick
);

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] lim;

    always_comb begin
        lim  = low_modulus(sel) - PC_W'(1) + {{(PC_W-1){1'b0}}, hi_mod};
        tick = (pc == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= '0;
        else if (tick) pc <= '0;
        else pc <= pc + PC_W'(1);
    end

    assert_pc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (pc == $past(pc) + PC_W'(1)));

    assert_pc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= low_modulus(sel) - PC_W'(1) + {{(PC_W-1){1'b0}}, hi_mod});

endmodule

// File: rtl/pswl_ctrl.sv
module pswl_ctrl
    import pswl_pkg::*;
#(
    parameter int AW = 5,
    parameter int BW = 13,
    parameter logic [AW-1:0] DEF_A = '0,
    parameter logic [BW-1:0] DEF_B = 13'd3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] ld_a,
    input  logic [BW-1:0] ld_b,
    output logic          hi_mod,
    output logic          boundary
);

    pswl_phase_t   state, nxt_state;
    logic [AW-1:0] a_cnt, nxt_a;
    logic [BW-1:0] b_cnt, nxt_b;

    always_comb begin
        nxt_state = state;
        nxt_a     = a_cnt;
        nxt_b     = b_cnt;
        if (tick) begin
            if (b_cnt == BW'(1)) begin
                nxt_a     = ld_a;
                nxt_b     = ld_b;
                nxt_state = (ld_a != '0) ? ST_SWALLOW : ST_MAIN;
            end else begin
                nxt_b = b_cnt - BW'(1);
                unique case (state)
                    ST_SWALLOW: begin
                        nxt_a = a_cnt - AW'(1);
                        if (a_cnt == AW'(1)) nxt_state = ST_MAIN;
                    end
                    ST_MAIN: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= (DEF_A != '0) ? ST_SWALLOW : ST_MAIN;
            a_cnt <= DEF_A;
            b_cnt <= DEF_B;
        end else begin
            state <= nxt_state;
            a_cnt <= nxt_a;
            b_cnt <= nxt_b;
        end
    end

    always_comb begin
        hi_mod   = (state == ST_SWALLOW);
        boundary = tick && (b_cnt == BW'(1));
    end

    assert_swallow_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWALLOW) |-> (a_cnt != '0));

    assert_a_le_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        {{(BW-AW){1'b0}}, a_cnt} <= b_cnt);

    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
    import pswl_pkg::*;
#(
    parameter int AW = 5,
    parameter int BW = 13,
    parameter logic [1:0] DEF_SEL = 2'd0,
    parameter logic [AW-1:0] DEF_A = '0,
    parameter logic [BW-1:0] DEF_B = 13'd3
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    psel,
    input  logic [AW-1:0] a_val,
    input  logic [BW-1:0] b_val,
    output logic          div_out,
    output logic          cfg_err
);

    logic [SEL_W-1:0] act_sel;
    logic [AW-1:0]    nxt_a;
    logic [BW-1:0]    nxt_b;
    logic             tick, hi_mod, boundary;

    pswl_cfg #(.AW(AW), .BW(BW), .DEF_SEL(DEF_SEL), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_cfg (
        .clk(clk_in), .rst_n(rst_n), .load(load), .sel_in(psel), .a_in(a_val),
        .b_in(b_val), .boundary(boundary), .act_sel(act_sel), .nxt_a(nxt_a),
        .nxt_b(nxt_b), .cfg_err(cfg_err)
    );

    pswl_prescaler u_pre (
        .clk(clk_in), .rst_n(rst_n), .sel(act_sel), .hi_mod(hi_mod), .tick(tick)
    );

    pswl_ctrl #(.AW(AW), .BW(BW), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_ctrl (
        .clk(clk_in), .rst_n(rst_n), .tick(tick), .ld_a(nxt_a), .ld_b(nxt_b),
        .hi_mod(hi_mod), .boundary(boundary)
    );

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) div_out <= 1'b0;
        else div_out <= boundary;
    end

    assert_pulse_single_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
        div_out |=> !div_out);

endmodule

// File: tb/test_pulse_swallow_divider.sv
module test_pulse_swallow_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [1:0]  psel = 2'd0;
    logic [4:0]  a_val = '0;
    logic [12:0] b_val = 13'd3;
    logic        div_out, cfg_err;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    int cnt, ncur, pend_n;
    bit pend_v, m_err, m_pulse;

    always #5 clk = ~clk;

    pulse_swallow_divider i_pulse_swallow_divider (
        .clk_in(clk), .rst_n(rst_n), .load(load), .psel(psel), .a_val(a_val),
        .b_val(b_val), .div_out(div_out), .cfg_err(cfg_err)
    );

    function automatic int pval(input logic [1:0] s);
        return 8 << s;
    endfunction

    function automatic bit is_legal(input logic [1:0] s, input int a, input int b);
        return (s != 2'd3) && (b >= 3) && (a <= b);
    endfunction

    // behavioural reference: edge counter against the expected ratio
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt = 0; ncur = 24; pend_v = 0; pend_n = 0; m_err = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (cnt + 1 == ncur) begin
                m_pulse = 1;
                cnt = 0;
                if (pend_v) ncur = pend_n;
                pend_v = 0;
            end else begin
                cnt++;
            end
            if (load) begin
                if (is_legal(psel, int'(a_val), int'(b_val))) begin
                    pend_n = int'(b_val) * pval(psel) + int'(a_val);
                    pend_v = 1;
                    m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (div_out !== m_pulse) begin
                fails++;
                $display("FAIL %s div_out actual %0b expected %0b at %0t", cur_req, div_out, m_pulse, $time);
            end
            if (cfg_err !== m_err) begin
                fails++;
                $display("FAIL %s cfg_err actual %0b expected %0b at %0t", cur_req, cfg_err, m_err, $time);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put_cfg(input logic [1:0] s, input int a, input int b);
        @(negedge clk);
        psel = s; a_val = 5'(a); b_val = 13'(b); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        idle(3);
        vectors++;
        if (div_out !== 1'b0 || cfg_err !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs actual %0b%0b expected 00", div_out, cfg_err);
        end
        rst_n = 1'b1;
        cur_req = "R1";
        idle(80);
        // R3 and R2: each modulus pair
        cur_req = "R3";
        put_cfg(2'd1, 5, 10);
        idle(400);
        put_cfg(2'd2, 7, 9);
        idle(700);
        cur_req = "R2";
        put_cfg(2'd0, 4, 20);
        idle(400);
        // R8 and R4: all-P and all-(P+1) swallow settings
        cur_req = "R8";
        put_cfg(2'd0, 0, 3);
        idle(100);
        put_cfg(2'd0, 3, 3);
        idle(100);
        put_cfg(2'd0, 31, 31);
        idle(700);
        cur_req = "R4";
        put_cfg(2'd1, 12, 12);
        idle(500);
        // R9: lowest contiguous ratios
        cur_req = "R9";
        put_cfg(2'd1, 0, 15);
        idle(600);
        put_cfg(2'd1, 1, 15);
        idle(600);
        // R5: illegal loads are rejected and the ratio is held
        cur_req = "R5";
        put_cfg(2'd0, 9, 4);
        idle(300);
        put_cfg(2'd0, 0, 2);
        idle(300);
        put_cfg(2'd3, 1, 5);
        idle(300);
        // R6: legal load clears the flag
        cur_req = "R6";
        put_cfg(2'd0, 2, 5);
        idle(200);
        // R7: mid-cycle and back-to-back loads
        cur_req = "R7";
        put_cfg(2'd2, 1, 3);
        put_cfg(2'd0, 1, 4);
        idle(7);
        put_cfg(2'd1, 3, 6);
        idle(300);
        for (int k = 0; k < 40; k++) begin
            int b = $urandom_range(40, 3);
            int a = $urandom_range((b > 31) ? 31 : b, 0);
            put_cfg(2'($urandom_range(2, 0)), a, b);
            idle($urandom_range(600, 0));
        end
        idle(1500);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule